// File: doc/BRIEF.md
# SGI Pending Source Register Bank

This block stores, for every CPU, a small mask per software-generated interrupt (SGI) that records which source CPUs have raised that SGI and not yet had it delivered. There are 16 SGIs per CPU, and each mask has one bit per possible source CPU, 8 in all. The masks are reached through a 32-bit register port. That port has two windows: a set window and a clear window. Each 32-bit word of a window packs four SGIs, one mask per byte. The lowest byte belongs to the lowest SGI of the word.

Software reaches the bank through the register port. Each access names the accessing CPU, and only that CPU's masks can be read or changed. A read returns the same four packed masks whichever window is used. A write to the set window ORs bits into the masks. A write to the clear window removes bits from the masks. A one-cycle update pulse reports every write that really changed a stored bit.

A separate delivery port removes a single source bit once that source's interrupt has been handed to its target CPU. An SGI shows as pending on its own output while any source bit remains in its mask.

Both the request port and the delivery port use a valid/ready handshake. Neither port ever applies back-pressure: both ready outputs are high in every cycle that reset is low, and low while reset is high. The read response is a one-cycle `rsp_valid` strobe and has no ready input. The consumer must take the response in that cycle.

Top module: `sgi_pend_bank`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all masks are zero, every `pend_o` bit is 0, and `rsp_valid` and `upd_o` are 0. `req_ready` and `dlv_ready` are 0 while `rst` is high.
- R2: A request addresses only the masks of CPU `req_cpu`. Within word `req_word`, bits [8n+7:8n] hold the mask of SGI 4*`req_word`+n. Bit k of a mask stands for source CPU k.
- R3: A write with `req_win`=0 (set window) ORs each data byte into the matching mask.
- R4: A write with `req_win`=1 (clear window) clears every mask bit whose data bit is 1, and leaves the other bits unchanged.
- R5: A read returns the four packed masks on `rsp_data`, with `rsp_valid` high, in the cycle after the request is accepted. The result is the same for `req_win`=0 and `req_win`=1. A write gives no response.
- R6: `upd_o` is high for one cycle, in the cycle after a write, only if that write changed at least one mask bit. The change is judged against the stored state before that cycle.
- R7: An accepted delivery clears bit `dlv_src` of the mask of SGI `dlv_sgi` of CPU `dlv_cpu`. Once that mask is empty, the SGI stops being pending. Delivering a bit that is already clear changes nothing.
- R8: `pend_o[c*16+s]` is high exactly when the mask of SGI s of CPU c is non-zero. It follows a change in the cycle after the change is accepted, and it stays steady while no write and no delivery is accepted.
- R9: When a write and a delivery reach the same mask in the same cycle, the write is applied first and the delivery's clear is applied on top of it.
- R10: Once `rst` is low, `req_ready` and `dlv_ready` are high in every cycle, so no request or delivery is ever stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready (high out of reset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 1 | Window select: 0 = set window, 1 = clear window |
| req_cpu | input | 3 | Accessing CPU; selects whose masks are used |
| req_word | input | 2 | Word index; covers SGIs 4*word to 4*word+3 |
| req_wdata | input | 32 | Write data, four mask bytes |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 32 | Read response, four packed mask bytes |
| upd_o | output | 1 | One-cycle pulse after a write that changed state |
| dlv_valid | input | 1 | Delivery valid |
| dlv_ready | output | 1 | Delivery ready (high out of reset) |
| dlv_cpu | input | 3 | CPU that received the SGI |
| dlv_sgi | input | 4 | SGI number delivered |
| dlv_src | input | 3 | Source CPU whose bit is removed |
| pend_o | output | 128 | Pending flags, bit c*16+s for SGI s of CPU c |

## Verification
Every result of this block appears in the cycle after the request or delivery is accepted on a rising edge. This covers the read word with its strobe, the update pulse, the new mask contents and the pending flags derived from them.

The bench therefore drives each stimulus at a falling edge. It samples every output at the next falling edge, after exactly one capturing rising edge, and then removes the stimulus. The effect of a mask change on a later read is checked with a separate read issued after that change. This keeps each expected value tied to one known edge.

// File: rtl/sgi_pend_pkg.sv
package sgi_pend_pkg;
  localparam int DATA_W = 32;
  localparam int MASK_W = 8;
  localparam int LANES  = DATA_W / MASK_W;

  typedef enum logic {
    WIN_SET = 1'b0,
    WIN_CLR = 1'b1
  } win_e;
endpackage

// File: rtl/sgi_lane_decode.sv
module sgi_lane_decode #(
  parameter int N_CPU = 8,
  parameter int N_SGI = 16,
  parameter int CPU_W = $clog2(N_CPU),
  parameter int WORD_W = $clog2(N_SGI / sgi_pend_pkg::LANES)
) (
  input  logic                                   wr_en,
  input  sgi_pend_pkg::win_e                     win,
  input  logic [CPU_W-1:0]                       cpu,
  input  logic [WORD_W-1:0]                      word,
  input  logic [sgi_pend_pkg::DATA_W-1:0]        wdata,
  output logic [N_CPU-1:0][N_SGI-1:0][sgi_pend_pkg::MASK_W-1:0] set_m,
  output logic [N_CPU-1:0][N_SGI-1:0][sgi_pend_pkg::MASK_W-1:0] clr_m
);
  import sgi_pend_pkg::*;
  localparam int LANE_W = $clog2(LANES);
  localparam int SGI_W  = WORD_W + LANE_W;

  // Spread the four write bytes onto the masks of the addressed CPU.
  always_comb begin
    logic [SGI_W-1:0] idx;
    set_m = '0;
    clr_m = '0;
    idx   = '0;
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        idx = {word, LANE_W'(l)};
        if (win == WIN_SET) set_m[cpu][idx] = wdata[l*MASK_W +: MASK_W];
        else                clr_m[cpu][idx] = wdata[l*MASK_W +: MASK_W];
      end
    end
  end
endmodule

// File: rtl/sgi_src_cell.sv
module sgi_src_cell #(
  parameter int MASK_W = sgi_pend_pkg::MASK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MASK_W-1:0] set_b,
  input  logic [MASK_W-1:0] clr_b,
  input  logic [MASK_W-1:0] dlv_b,
  output logic [MASK_W-1:0] mask_q
);
  // Register write first, then the delivery removal on top of it.
  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= ((mask_q | set_b) & ~clr_b) & ~dlv_b;
  end
endmodule

// File: rtl/sgi_word_view.sv
module sgi_word_view #(
  parameter int N_CPU = 8,
  parameter int N_SGI = 16,
  parameter int CPU_W = $clog2(N_CPU),
  parameter int WORD_W = $clog2(N_SGI / sgi_pend_pkg::LANES)
) (
  input  logic [N_CPU-1:0][N_SGI-1:0][sgi_pend_pkg::MASK_W-1:0] masks,
  input  logic [CPU_W-1:0]                                      cpu,
  input  logic [WORD_W-1:0]                                     word,
  output logic [sgi_pend_pkg::DATA_W-1:0]                       view
);
  import sgi_pend_pkg::*;
  localparam int LANE_W = $clog2(LANES);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign view[l*MASK_W +: MASK_W] = masks[cpu][{word, LANE_W'(l)}];
  end
endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank #(
  parameter int N_CPU = 8,
  parameter int N_SGI = 16,
  localparam int CPU_W  = $clog2(N_CPU),
  localparam int SGI_W  = $clog2(N_SGI),
  localparam int SRC_W  = $clog2(sgi_pend_pkg::MASK_W),
  localparam int WORD_W = $clog2(N_SGI / sgi_pend_pkg::LANES)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic                        req_win,
  input  logic [CPU_W-1:0]            req_cpu,
  input  logic [WORD_W-1:0]           req_word,
  input  logic [31:0]                 req_wdata,
  output logic                        rsp_valid,
  output logic [31:0]                 rsp_data,
  output logic                        upd_o,
  input  logic                        dlv_valid,
  output logic                        dlv_ready,
  input  logic [CPU_W-1:0]            dlv_cpu,
  input  logic [SGI_W-1:0]            dlv_sgi,
  input  logic [SRC_W-1:0]            dlv_src,
  output logic [N_CPU*N_SGI-1:0]      pend_o
);
  import sgi_pend_pkg::*;

  typedef logic [N_CPU-1:0][N_SGI-1:0][MASK_W-1:0] bank_t;

  bank_t mask_q, set_m, clr_m, dlv_m;
  logic  wr_acc, rd_acc, dlv_acc, changed;
  logic [DATA_W-1:0] view;
  win_e  win;

  assign req_ready = ~rst;
  assign dlv_ready = ~rst;
  assign wr_acc  = req_valid & req_ready & req_write;
  assign rd_acc  = req_valid & req_ready & ~req_write;
  assign dlv_acc = dlv_valid & dlv_ready;
  assign win     = win_e'(req_win);

  sgi_lane_decode #(.N_CPU(N_CPU), .N_SGI(N_SGI)) u_dec (
    .wr_en (wr_acc),
    .win   (win),
    .cpu   (req_cpu),
    .word  (req_word),
    .wdata (req_wdata),
    .set_m (set_m),
    .clr_m (clr_m)
  );

  // One-hot removal of a single delivered source bit.
  always_comb begin
    dlv_m = '0;
    if (dlv_acc) dlv_m[dlv_cpu][dlv_sgi][dlv_src] = 1'b1;
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    for (genvar s = 0; s < N_SGI; s++) begin : g_sgi
      sgi_src_cell u_cell (
        .clk    (clk),
        .rst    (rst),
        .set_b  (set_m[c][s]),
        .clr_b  (clr_m[c][s]),
        .dlv_b  (dlv_m[c][s]),
        .mask_q (mask_q[c][s])
      );
      assign pend_o[c*N_SGI+s] = |mask_q[c][s];
    end
  end

  sgi_word_view #(.N_CPU(N_CPU), .N_SGI(N_SGI)) u_view (
    .masks (mask_q),
    .cpu   (req_cpu),
    .word  (req_word),
    .view  (view)
  );

  // The same view serves the read path and the change detector.
  assign changed = (win == WIN_SET) ? |(req_wdata & ~view) : |(req_wdata & view);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      upd_o     <= 1'b0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_data <= view;
      upd_o     <= wr_acc & changed;
    end
  end
endmodule

// File: rtl/sgi_pend_bank_chk.sv
module sgi_pend_bank_chk #(
  parameter int N_CPU = 8,
  parameter int N_SGI = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_write,
  input logic                   req_win,
  input logic                   rsp_valid,
  input logic                   upd_o,
  input logic                   dlv_valid,
  input logic                   dlv_ready,
  input logic [N_CPU*N_SGI-1:0] pend_o
);
  logic rd_acc, wr_acc, set_acc, dlv_acc;
  assign rd_acc  = req_valid & req_ready & ~req_write;
  assign wr_acc  = req_valid & req_ready & req_write;
  assign set_acc = wr_acc & ~req_win;
  assign dlv_acc = dlv_valid & dlv_ready;

  // R5: an accepted read is answered in the next cycle
  p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> rsp_valid);

  // R5: no response strobe without an accepted read
  p_no_rsp_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |=> !rsp_valid);

  // R6: update pulse only follows a write
  p_no_upd_without_write_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_acc |=> !upd_o);

  // R8: pending flags hold when nothing touches the bank
  p_pend_stable_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!wr_acc && !dlv_acc) |=> $stable(pend_o));

  // R3: a pending flag can only rise after a set-window write
  p_pend_rise_needs_set_r3: assert property (@(posedge clk) disable iff (rst)
    (|(pend_o & ~$past(pend_o))) |-> $past(set_acc));
endmodule

bind sgi_pend_bank sgi_pend_bank_chk #(.N_CPU(N_CPU), .N_SGI(N_SGI)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_win   (req_win),
  .rsp_valid (rsp_valid),
  .upd_o     (upd_o),
  .dlv_valid (dlv_valid),
  .dlv_ready (dlv_ready),
  .pend_o    (pend_o)
);

// File: tb/tb_sgi_pend_bank.sv
module tb_sgi_pend_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_win = 1'b0;
  logic [2:0]  req_cpu = '0;
  logic [1:0]  req_word = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, upd_o, req_ready, dlv_ready;
  logic [31:0] rsp_data;
  logic        dlv_valid = 1'b0;
  logic [2:0]  dlv_cpu = '0, dlv_src = '0;
  logic [3:0]  dlv_sgi = '0;
  logic [127:0] pend_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic        g_rv, g_upd;
  logic [31:0] g_rd;

  always #4 clk = ~clk;

  sgi_pend_bank dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_win(req_win), .req_cpu(req_cpu),
    .req_word(req_word), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .upd_o(upd_o), .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready), .dlv_cpu(dlv_cpu), .dlv_sgi(dlv_sgi),
    .dlv_src(dlv_src), .pend_o(pend_o)
  );

  // op: 0 set write, 1 clear write, 2 read via set window, 3 read via clear window
  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  cpu;
    logic [1:0]  word;
    logic [31:0] data;
    logic [31:0] exp;
    logic        upd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd2, 2'd1, 32'h0000_0301, 32'h0, 1'b1},
    '{2'd2, 3'd2, 2'd1, 32'h0,         32'h0000_0301, 1'b0},
    '{2'd3, 3'd2, 2'd1, 32'h0,         32'h0000_0301, 1'b0},
    '{2'd0, 3'd2, 2'd1, 32'h0000_0201, 32'h0, 1'b0},
    '{2'd0, 3'd2, 2'd1, 32'h8000_0000, 32'h0, 1'b1},
    '{2'd2, 3'd2, 2'd1, 32'h0,         32'h8000_0301, 1'b0},
    '{2'd1, 3'd2, 2'd1, 32'h0000_0100, 32'h0, 1'b1},
    '{2'd1, 3'd2, 2'd1, 32'h0000_0100, 32'h0, 1'b0},
    '{2'd3, 3'd2, 2'd1, 32'h0,         32'h8000_0201, 1'b0},
    '{2'd2, 3'd3, 2'd1, 32'h0,         32'h0, 1'b0},
    '{2'd2, 3'd2, 2'd0, 32'h0,         32'h0, 1'b0},
    '{2'd0, 3'd7, 2'd3, 32'hFF00_0000, 32'h0, 1'b1},
    '{2'd3, 3'd7, 2'd3, 32'h0,         32'hFF00_0000, 1'b0},
    '{2'd1, 3'd7, 2'd3, 32'h0F00_0000, 32'h0, 1'b1},
    '{2'd2, 3'd7, 2'd3, 32'h0,         32'hF000_0000, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus, sample at the following falling edge.
  task automatic issue(input logic [1:0] op, input logic [2:0] cpu,
                       input logic [1:0] word, input logic [31:0] data,
                       input logic dv, input logic [2:0] dcpu,
                       input logic [3:0] dsgi, input logic [2:0] dsrc,
                       input logic rv);
    @(negedge clk);
    req_valid = rv; req_write = ~op[1]; req_win = op[0];
    req_cpu = cpu; req_word = word; req_wdata = data;
    dlv_valid = dv; dlv_cpu = dcpu; dlv_sgi = dsgi; dlv_src = dsrc;
    @(negedge clk);
    g_rv = rsp_valid; g_rd = rsp_data; g_upd = upd_o;
    req_valid = 1'b0; dlv_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] cpu, input logic [1:0] word,
                        input logic [31:0] exp, input string req);
    issue(2'd2, cpu, word, 32'h0, 1'b0, 3'd0, 4'd0, 3'd0, 1'b1);
    check(g_rv && g_rd == exp, req, g_rd, exp);
  endtask

  task automatic dlv(input logic [2:0] c, input logic [3:0] s, input logic [2:0] src);
    issue(2'd2, 3'd0, 2'd0, 32'h0, 1'b1, c, s, src, 1'b0);
  endtask

  initial begin
    // R1: state during and right after reset
    repeat (3) @(negedge clk);
    check(!req_ready && !dlv_ready, "R1 ready low in reset", {req_ready, dlv_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pend_o == '0 && !rsp_valid && !upd_o, "R1 idle after reset",
          {29'd0, |pend_o, rsp_valid, upd_o}, 0);
    check(req_ready && dlv_ready, "R10 ready after reset", {req_ready, dlv_ready}, 2'b11);

    // Table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i].op, VEC[i].cpu, VEC[i].word, VEC[i].data, 1'b0, 3'd0, 4'd0, 3'd0, 1'b1);
      if (VEC[i].op[1]) begin
        check(g_rv && g_rd == VEC[i].exp, $sformatf("R5/R2 read vec %0d", i), g_rd, VEC[i].exp);
        check(!g_upd, $sformatf("R6 no upd on read vec %0d", i), g_upd, 0);
      end else begin
        check(!g_rv, $sformatf("R5 no rsp on write vec %0d", i), g_rv, 0);
        check(g_upd == VEC[i].upd, $sformatf("R6 upd vec %0d", i), g_upd, VEC[i].upd);
      end
    end

    // R8: pending flags reflect non-empty masks
    check(pend_o[36] && pend_o[37] && !pend_o[38] && pend_o[39] && pend_o[127],
          "R8 pending set", pend_o[39:36], 4'hB);
    check($countones(pend_o) == 4, "R8 pending count", $countones(pend_o), 4);

    // R7: delivering the only source drops pending
    dlv(3'd2, 4'd4, 3'd0);
    check(!pend_o[36], "R7 pending drops", pend_o[36], 0);
    rd_chk(3'd2, 2'd1, 32'h8000_0200, "R7 mask after delivery");
    // R7: delivering an absent source bit changes nothing
    dlv(3'd2, 4'd7, 3'd0);
    check(pend_o[39], "R7 absent bit keeps pending", pend_o[39], 1);
    rd_chk(3'd2, 2'd1, 32'h8000_0200, "R7 absent bit keeps mask");
    dlv(3'd2, 4'd5, 3'd1);
    check(!pend_o[37], "R7 last source clears pending", pend_o[37], 0);

    // R9: write and delivery on the same mask in one cycle
    issue(2'd0, 3'd7, 2'd3, 32'h0100_0000, 1'b1, 3'd7, 4'd15, 3'd4, 1'b1);
    check(g_upd, "R6 upd with concurrent delivery", g_upd, 1);
    rd_chk(3'd7, 2'd3, 32'hE100_0000, "R9 write then delivery");
    issue(2'd0, 3'd7, 2'd3, 32'h1000_0000, 1'b1, 3'd7, 4'd15, 3'd4, 1'b1);
    rd_chk(3'd7, 2'd3, 32'hE100_0000, "R9 delivery overrides set of same bit");

    // R1: reset in mid-run empties every mask
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(!req_ready && !dlv_ready && !rsp_valid, "R1 mid-run reset", {req_ready, dlv_ready}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(pend_o == '0, "R1 pending cleared", |pend_o, 0);
    rd_chk(3'd7, 2'd3, 32'h0, "R1 mask cleared");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule